// File: doc/BRIEF.md
# Cut-Through Region Router

The block takes parallel word streams from several upstream serializer channels and steers them onto a small set of output links, one for each radial region. Each input belongs to one region, set by a parameter. The block works on the rule that, in a given bunch crossing, at most one input of a region carries data. A frame is four 30-bit words. Its first word is flagged by a start-of-frame strobe, and the top bit of that word says whether the frame carries hits.

The block does not buffer whole frames. It decides the route from the header word alone and puts that word on the region's output one clock later. The remaining words then pass through with the same fixed delay.

Each region has its own small state machine with two states:
- `S_IDLE`: the region output carries the idle word.
- `S_FWD`: the region output carries the selected input's words.

There are three transitions:
- *take*: `S_IDLE` to `S_FWD`, when an active header arrives.
- *stream*: `S_FWD` to `S_FWD`, while words of the frame remain.
- *release*: `S_FWD` to `S_IDLE`, after the fourth word.

Top module: `cut_through_router`

## Requirements
- R1: After reset every region output carries the idle word, and `out_sof`, `out_valid` and `out_collide` are all low.
- R2: An input word counts as an active header only when `in_valid`, `in_sof` and data bit 29 are all high. A header with bit 29 low is not forwarded.
- R3: The header word of a routed frame appears on its region's `out_data` exactly one clock after it is presented. In that cycle `out_sof=1` and `out_valid=1`.
- R4: The three words that follow the header are forwarded on the next three cycles with `out_valid=1` and `out_sof=0`. The lane is then free again, so a header arriving on the cycle after the fourth word is taken.
- R5: When two or more active headers of one region arrive in the same cycle, the lowest-index input is forwarded and `out_collide` is high alongside the first output word.
- R6: While a region routes nothing, its `out_data` is the idle word (all zeros, so bit 29 is clear) and `out_valid` is low.
- R7: An active header on another input of a region that is already forwarding is not forwarded. It raises `out_collide` in the output cycle that corresponds to its arrival.
- R8: Input i belongs to the region held in bits [2i+1:2i] of `REGION_MAP`. The default map places inputs 0,1 in region 0, inputs 2,3 in region 1 and inputs 4,5 in region 2. The regions operate independently.
- R9: Words with `in_valid` low are ignored, whatever `in_sof` and the data carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | N_IN*W | Input words, input i in bits [i*W +: W] |
| in_sof | input | N_IN | First word of a frame, per input |
| in_valid | input | N_IN | Word present, per input |
| out_data | output | N_REG*W | Region words, region r in bits [r*W +: W] |
| out_sof | output | N_REG | First word of a forwarded frame |
| out_valid | output | N_REG | Region carries frame data |
| out_collide | output | N_REG | A second active source was seen in the region |

## Verification
The assertions take for granted two things about the inputs. First, a source whose header was taken delivers its remaining three words on the next three cycles. Second, a frame is at least two words long, so a start-of-frame output is always followed by a non-start word. The stimulus meets both conditions by building every frame as four consecutive valid words from one input, with frames placed back to back in four-cycle crossings. Random per-input choices cover several cases: no data, an active frame, or an empty header, with junk on invalid inputs. Directed cases add same-cycle collisions and a stray single-word header on a busy region.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    // Width of one field of the input-to-region map.
    localparam int unsigned REGION_FIELD_W = 2;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_FWD  = 1'b1
    } lane_state_e;
endpackage

// File: rtl/ctr_first_req.sv
module ctr_first_req #(
    parameter int unsigned N  = 6,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any_req,
    output logic          multi_req,
    output logic [IW-1:0] first_idx
);
    always_comb begin
        int unsigned hits;
        hits      = 0;
        first_idx = '0;
        // Scan from the top down so the lowest set index wins.
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                first_idx = IW'(i);
                hits      = hits + 1;
            end
        end
        any_req   = (hits != 0);
        multi_req = (hits > 1);
    end
endmodule

// File: rtl/ctr_region_lane.sv
module ctr_region_lane
    import ctr_pkg::*;
#(
    parameter int unsigned N_IN      = 6,
    parameter int unsigned W         = 30,
    parameter int unsigned FRAME_LEN = 4,
    parameter logic [W-1:0] IDLE_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   cand,
    input  logic [N_IN*W-1:0] in_data,
    output logic [W-1:0]      out_data,
    output logic              out_sof,
    output logic              out_valid,
    output logic              out_collide
);
    localparam int unsigned IW = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int unsigned CW = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_LEN - 1);

    lane_state_e   state_q, state_d;
    logic [IW-1:0] sel_q;
    logic [CW-1:0] cnt_q;
    logic          any_req, multi_req;
    logic [IW-1:0] pick_idx;

    ctr_first_req #(.N(N_IN), .IW(IW)) i_pick (
        .req       (cand),
        .any_req   (any_req),
        .multi_req (multi_req),
        .first_idx (pick_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: take, stream, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (any_req)            state_d = S_FWD;
            S_FWD:  if (cnt_q == LAST_CNT)  state_d = S_IDLE;
        endcase
    end

    // Registered outputs and lane bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q       <= '0;
            cnt_q       <= '0;
            out_data    <= IDLE_WORD;
            out_sof     <= 1'b0;
            out_valid   <= 1'b0;
            out_collide <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (any_req) begin
                        sel_q       <= pick_idx;
                        cnt_q       <= CW'(1);
                        out_data    <= in_data[pick_idx*W +: W];
                        out_sof     <= 1'b1;
                        out_valid   <= 1'b1;
                        out_collide <= multi_req;
                    end else begin
                        cnt_q       <= '0;
                        out_data    <= IDLE_WORD;
                        out_sof     <= 1'b0;
                        out_valid   <= 1'b0;
                        out_collide <= 1'b0;
                    end
                end
                S_FWD: begin
                    cnt_q       <= cnt_q + CW'(1);
                    out_data    <= in_data[sel_q*W +: W];
                    out_sof     <= 1'b0;
                    out_valid   <= 1'b1;
                    out_collide <= any_req;
                end
            endcase
        end
    end

    // R3
    take_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && any_req) |=> (out_sof && out_valid));
    // R4
    frame_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |=> (out_valid && !out_sof));
    // R6
    idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == IDLE_WORD));
    // R5
    collide_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_collide |-> out_valid);
    // R2
    active_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_data[W-1]);
endmodule

// File: rtl/cut_through_router.sv
module cut_through_router
    import ctr_pkg::*;
#(
    parameter int unsigned N_IN      = 6,
    parameter int unsigned N_REG     = 3,
    parameter int unsigned W         = 30,
    parameter int unsigned FRAME_LEN = 4,
    parameter logic [N_IN*REGION_FIELD_W-1:0] REGION_MAP = 12'b10_10_01_01_00_00,
    parameter logic [W-1:0] IDLE_WORD = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IN*W-1:0]  in_data,
    input  logic [N_IN-1:0]    in_sof,
    input  logic [N_IN-1:0]    in_valid,
    output logic [N_REG*W-1:0] out_data,
    output logic [N_REG-1:0]   out_sof,
    output logic [N_REG-1:0]   out_valid,
    output logic [N_REG-1:0]   out_collide
);
    localparam int unsigned RF = REGION_FIELD_W;

    logic [N_IN-1:0] hdr_active;

    for (genvar i = 0; i < N_IN; i++) begin : g_hdr
        assign hdr_active[i] = in_valid[i] & in_sof[i] & in_data[i*W + W - 1];
    end

    for (genvar r = 0; r < N_REG; r++) begin : g_region
        logic [N_IN-1:0] cand;
        for (genvar i = 0; i < N_IN; i++) begin : g_member
            assign cand[i] = hdr_active[i] &
                             (REGION_MAP[i*RF +: RF] == RF'(r));
        end

        ctr_region_lane #(
            .N_IN(N_IN), .W(W), .FRAME_LEN(FRAME_LEN), .IDLE_WORD(IDLE_WORD)
        ) i_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .cand        (cand),
            .in_data     (in_data),
            .out_data    (out_data[r*W +: W]),
            .out_sof     (out_sof[r]),
            .out_valid   (out_valid[r]),
            .out_collide (out_collide[r])
        );
    end
endmodule

// File: tb/test_cut_through_router.sv
module test_cut_through_router;
    localparam int N_IN = 6;
    localparam int N_REG = 3;
    localparam int W = 30;
    localparam logic [11:0] MAP = 12'b10_10_01_01_00_00;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N_IN*W-1:0]  in_data = '0;
    logic [N_IN-1:0]    in_sof = '0;
    logic [N_IN-1:0]    in_valid = '0;
    logic [N_REG*W-1:0] out_data;
    logic [N_REG-1:0]   out_sof, out_valid, out_collide;

    cut_through_router #(.N_IN(N_IN), .N_REG(N_REG), .W(W), .FRAME_LEN(4),
                         .REGION_MAP(MAP), .IDLE_WORD('0)) i_cut_through_router (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_sof(in_sof),
        .in_valid(in_valid), .out_data(out_data), .out_sof(out_sof),
        .out_valid(out_valid), .out_collide(out_collide));

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    logic [W-1:0] fw [N_IN][4];
    bit snd [N_IN];
    logic [W-1:0] exp_d [N_REG];
    bit exp_s [N_REG], exp_v [N_REG], exp_c [N_REG];
    string tag [N_REG];
    bit pend = 0;

    function automatic int region_of(input int i);
        return int'(MAP[2*i +: 2]);   // R8
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic check_prev();
        if (!pend) return;
        for (int r = 0; r < N_REG; r++) begin
            n_chk++;
            if (out_data[r*W +: W] !== exp_d[r] || out_sof[r] !== exp_s[r] ||
                out_valid[r] !== exp_v[r] || out_collide[r] !== exp_c[r]) begin
                n_err++;
                $display("FAIL %s region %0d: got d=%h s=%b v=%b c=%b, expected d=%h s=%b v=%b c=%b",
                         tag[r], r, out_data[r*W +: W], out_sof[r], out_valid[r], out_collide[r],
                         exp_d[r], exp_s[r], exp_v[r], exp_c[r]);
            end
        end
    endtask

    // Build a frame for input i; act sets the header's bit 29 (R2).
    task automatic make_frame(input int i, input bit act);
        fw[i][0] = {act, 29'($urandom)};
        for (int c = 1; c < 4; c++) fw[i][c] = W'($urandom);
        snd[i] = 1;
    endtask

    task automatic clear_plan();
        for (int i = 0; i < N_IN; i++) snd[i] = 0;
    endtask

    // One four-cycle crossing; late_i >= 0 adds a one-word stray header at late_c.
    task automatic run_slot(input int late_i, input int late_c);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check_prev();
            for (int i = 0; i < N_IN; i++) begin
                if (snd[i]) begin
                    in_valid[i] = 1'b1;
                    in_sof[i]   = (c == 0);
                    in_data[i*W +: W] = fw[i][c];
                end else begin
                    in_valid[i] = 1'b0;          // R9 junk
                    in_sof[i]   = 1'($urandom);
                    in_data[i*W +: W] = W'($urandom);
                end
            end
            if (late_i >= 0 && c == late_c) begin
                in_valid[late_i] = 1'b1;
                in_sof[late_i]   = 1'b1;
                in_data[late_i*W +: W] = {1'b1, 29'($urandom)};
            end
            for (int r = 0; r < N_REG; r++) begin
                int first = -1;
                int cnt = 0;
                for (int i = 0; i < N_IN; i++)
                    if (snd[i] && fw[i][0][W-1] && region_of(i) == r) begin
                        if (first < 0) first = i;
                        cnt++;
                    end
                exp_v[r] = (first >= 0);
                exp_s[r] = (first >= 0) && (c == 0);
                exp_d[r] = (first >= 0) ? fw[first][c] : '0;
                exp_c[r] = ((c == 0) && cnt >= 2) ||
                           (late_i >= 0 && c == late_c && region_of(late_i) == r && first >= 0);
                if (first < 0)               tag[r] = "R6";
                else if (late_i >= 0 && c == late_c && region_of(late_i) == r) tag[r] = "R7";
                else if (c == 0 && cnt >= 2) tag[r] = "R5";
                else if (c == 0)             tag[r] = "R3";
                else                         tag[r] = "R4";
            end
            pend = 1;
        end
    endtask

    task automatic idle_step();
        @(negedge clk);
        check_prev();
        in_valid = '0;
        in_sof   = '0;
        in_data  = '0;
        for (int r = 0; r < N_REG; r++) begin
            exp_d[r] = '0; exp_s[r] = 0; exp_v[r] = 0; exp_c[r] = 0; tag[r] = "R6";
        end
        pend = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        for (int r = 0; r < N_REG; r++) begin
            n_chk++;
            if (out_data[r*W +: W] !== '0 || out_sof[r] !== 0 || out_valid[r] !== 0 || out_collide[r] !== 0) begin
                n_err++;
                $display("FAIL R1 region %0d: got d=%h s=%b v=%b c=%b, expected idle",
                         r, out_data[r*W +: W], out_sof[r], out_valid[r], out_collide[r]);
            end
        end
        rst_n = 1'b1;
        idle_step();

        // R3 R4 R8: one source in each region, upper inputs
        clear_plan(); make_frame(1, 1); make_frame(3, 1); make_frame(5, 1);
        run_slot(-1, 0);
        // R4: back-to-back frame taken on the next cycle, lower inputs
        clear_plan(); make_frame(0, 1); make_frame(2, 1); make_frame(4, 1);
        run_slot(-1, 0);
        // R5: same-cycle collision in regions 0 and 2
        clear_plan(); make_frame(0, 1); make_frame(1, 1); make_frame(4, 1); make_frame(5, 1);
        run_slot(-1, 0);
        // R2: empty header not forwarded; region 1 active only
        clear_plan(); make_frame(0, 0); make_frame(3, 1);
        run_slot(-1, 0);
        // R7: stray header on input 1 while region 0 forwards input 0
        clear_plan(); make_frame(0, 1);
        run_slot(1, 2);
        idle_step();
        // R9: nothing valid, junk on the inputs
        clear_plan();
        run_slot(-1, 0);

        // Random crossings
        for (int k = 0; k < 60; k++) begin
            clear_plan();
            for (int i = 0; i < N_IN; i++) begin
                int pick = $urandom % 4;
                if (pick == 1 || pick == 2) make_frame(i, 1);
                else if (pick == 3)         make_frame(i, 0);
            end
            run_slot(-1, 0);
            if ($urandom % 4 == 0) idle_step();
        end
        idle_step();
        @(negedge clk);
        check_prev();
        finish_run();
    end
endmodule